// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block is the serial heart of a UART: a baud tick generator, a transmit shifter and a receive shifter, all steered by a set of static configuration inputs. The character length is chosen from five to eight bits. Parity is optional and is set up on its own for each direction, as even or odd. One or two stop bits can be selected. A break can be forced on the line, and an internal loopback can turn the transmitter back onto the receiver. The receiver tags each character it delivers with parity-error, framing-error and break flags.

Software-visible registers and the FIFOs are outside the block. The transmit side takes bytes through a valid/ready pair. The receive side emits a one-cycle write strobe with the byte and its flags, ready for a FIFO write port. The baud generator, transmitter and receiver each have their own enable, so the format can be changed safely while all three are held off. Two modem control outputs drive the inverse of their configuration bits.

Top module: `uart_frame_engine`

## Requirements
- R1: The baud generator emits one tick every `baud_word`+1 clock cycles while `cfg_brg_en` is high, and a serial bit lasts 16 ticks, so one bit is 16×(`baud_word`+1) clocks. While `cfg_brg_en` is low no ticks occur and a frame in progress does not advance.
- R2: `cfg_bits_code` sets the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The transmitter sends a low start bit and then the data bits least significant first, and ignores data bits above the selected length.
- R3: `cfg_two_stop` low gives one high stop bit and high gives two, so an 8-bit frame with no parity lasts 10 or 11 bit times.
- R4: When `cfg_tx_par_en` is high, one parity bit follows the data. It makes the count of ones even when `cfg_tx_par_odd` is 0, and odd when it is 1.
- R5: The receiver looks for a low start bit at its midpoint (tick 8), samples each bit in its middle, least significant bit first, and pulses `rx_valid` for exactly one cycle per character. `rx_data` holds the character right-aligned, with the unused upper bits zero.
- R6: When `cfg_rx_par_en` is high, `rx_par_err` is set if the received parity bit does not give even parity (select 0) or odd parity (select 1).
- R7: A stop bit sampled low on a character that is not all zero sets `rx_frm_err` and still delivers the data.
- R8: An all-zero character with a low stop bit is reported with `rx_brk`=1, `rx_data`=0 and both error flags clear. The receiver then waits for the line to go high before it looks for a new start bit.
- R9: While `cfg_break` is high, and loopback is off, `serial_out` is held low from the second clock edge onward, whatever the transmitter is doing.
- R10: While `cfg_loop` is high, the receiver takes the transmitter's output, including any break, `serial_in` is ignored and `serial_out` stays high.
- R11: With `cfg_tx_en` low, `tx_ready` is low and `serial_out` is high. With `cfg_rx_en` low, `rx_valid` never rises.
- R12: One clock after any change, `dtr_n` and `rts_n` show the inverse of `cfg_dtr_bit` and `cfg_rts_bit`.
- R13: During and directly after reset, `serial_out`, `dtr_n` and `rts_n` are high and `rx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_brg_en | input | 1 | Baud generator enable |
| cfg_tx_en | input | 1 | Transmitter enable |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_bits_code | input | 2 | Character length code (5 + code bits) |
| cfg_two_stop | input | 1 | Two stop bits when high |
| cfg_tx_par_en | input | 1 | Transmit parity enable |
| cfg_tx_par_odd | input | 1 | Transmit parity odd when high |
| cfg_rx_par_en | input | 1 | Receive parity enable |
| cfg_rx_par_odd | input | 1 | Receive parity odd when high |
| cfg_break | input | 1 | Force the line low |
| cfg_loop | input | 1 | Internal loopback |
| cfg_dtr_bit | input | 1 | Data-terminal-ready control bit |
| cfg_rts_bit | input | 1 | Request-to-send control bit |
| baud_word | input | BAUD_W | Tick divisor minus one |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter accepts a byte |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | One-cycle receive strobe |
| rx_par_err | output | 1 | Parity error flag |
| rx_frm_err | output | 1 | Framing error flag |
| rx_brk | output | 1 | Break flag |
| serial_in | input | 1 | Serial receive line |
| serial_out | output | 1 | Serial transmit line |
| dtr_n | output | 1 | Inverted DTR pin |
| rts_n | output | 1 | Inverted RTS pin |

## Verification
The bench builds the block with its default parameters: a 12-bit baud word and a two-stage input synchronizer. It runs with baud words of 1 and 3, so a bit lasts 32 or 64 clocks. These short bits let every character length, both stop settings, both parity senses, framing errors, breaks and loopback fit into a few thousand cycles each. The second baud value shows that the bit period follows the divisor and is not fixed.

// File: rtl/uart_fe_pkg.sv
// Package: shared state encoding and helper functions for the UART frame engine.
// Assumes characters of at most eight bits and sixteen ticks per bit.
package uart_fe_pkg;
    localparam int CHAR_W    = 8;
    localparam int TICK_W    = 4;
    localparam logic [TICK_W-1:0] LAST_TICK = 4'd15;
    localparam logic [TICK_W-1:0] MID_TICK  = 4'd7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } frame_st_t;

    // Number of data bits for a length code.
    function automatic logic [3:0] sym_len(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    // Mask keeping only the bits inside the selected character length.
    function automatic logic [CHAR_W-1:0] sym_mask(input logic [1:0] code);
        return 8'hFF >> (2'd3 - code);
    endfunction

    // Parity bit that makes the total count of ones even (odd=0) or odd (odd=1).
    function automatic logic parity_bit(input logic [CHAR_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction
endpackage

// File: rtl/uart_fe_baud.sv
// Module: baud tick generator. Produces a one-cycle tick every div+1 clocks
// while enabled. Assumes div is held stable while enabled.
module uart_fe_baud #(
    parameter int BAUD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [BAUD_W-1:0] div,
    output logic              tick
);
    logic [BAUD_W-1:0] cnt;

    // Divide the clock and emit a registered tick at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == div) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_fe_tx.sv
// Module: transmit shifter. Sends start, 5..8 data bits LSB first, optional
// parity and one or two stop bits, each bit sixteen ticks long. Drives both
// the external pin and an internal copy for loopback. Assumes format inputs
// are stable while enabled.
module uart_fe_tx
    import uart_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic [1:0]        bits_code,
    input  logic              two_stop,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              brk,
    input  logic              loop,
    input  logic [CHAR_W-1:0] data,
    input  logic              valid,
    output logic              ready,
    output logic              pin_line,
    output logic              int_line
);
    frame_st_t         state;
    logic [TICK_W-1:0] tcnt;
    logic [CHAR_W-1:0] shreg;
    logic [2:0]        bidx;
    logic              extra_stop;
    logic              par_q;
    logic              bit_now;
    logic [3:0]        len;

    assign len   = sym_len(bits_code);
    assign ready = en && (state == ST_IDLE);

    // Select the level of the bit currently being sent.
    always_comb begin
        case (state)
            ST_START: bit_now = 1'b0;
            ST_DATA:  bit_now = shreg[0];
            ST_PAR:   bit_now = par_q;
            default:  bit_now = 1'b1;
        endcase
    end

    // Frame sequencer: accept a byte, then step through the bits on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            tcnt       <= '0;
            shreg      <= '0;
            bidx       <= '0;
            extra_stop <= 1'b0;
            par_q      <= 1'b0;
        end else if (!en) begin
            state <= ST_IDLE;
            tcnt  <= '0;
        end else if (state == ST_IDLE) begin
            if (valid) begin
                shreg      <= data & sym_mask(bits_code);
                par_q      <= parity_bit(data & sym_mask(bits_code), par_odd);
                state      <= ST_START;
                tcnt       <= '0;
                bidx       <= '0;
                extra_stop <= 1'b0;
            end
        end else if (tick) begin
            tcnt <= tcnt + 4'd1;
            if (tcnt == LAST_TICK) begin
                case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        shreg <= shreg >> 1;
                        bidx  <= bidx + 3'd1;
                        if ({1'b0, bidx} == len - 4'd1)
                            state <= par_en ? ST_PAR : ST_STOP;
                    end
                    ST_PAR:  state <= ST_STOP;
                    ST_STOP: begin
                        if (two_stop && !extra_stop)
                            extra_stop <= 1'b1;
                        else
                            state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Register the line levels; break overrides data, loopback parks the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_line <= 1'b1;
            int_line <= 1'b1;
        end else begin
            int_line <= brk ? 1'b0 : bit_now;
            pin_line <= loop ? 1'b1 : (brk ? 1'b0 : bit_now);
        end
    end
endmodule

// File: rtl/uart_fe_rx.sv
// Module: receive shifter. Confirms the start bit at mid-bit, samples each
// following bit in its centre, checks parity and stop, and flags breaks.
// Assumes line_in is already synchronous to clk.
module uart_fe_rx
    import uart_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic [1:0]        bits_code,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              line_in,
    output logic              valid,
    output logic [CHAR_W-1:0] data,
    output logic              par_err,
    output logic              frm_err,
    output logic              brk_flag
);
    frame_st_t         state;
    logic [TICK_W-1:0] tcnt;
    logic [CHAR_W-1:0] shreg;
    logic [2:0]        bidx;
    logic              par_seen;
    logic [3:0]        len;
    logic [CHAR_W-1:0] aligned;
    logic              stop_low;
    logic              is_brk;

    assign len      = sym_len(bits_code);
    assign aligned  = shreg >> (4'd8 - len);
    assign stop_low = !line_in;
    assign is_brk   = stop_low && (aligned == '0);

    // Receive sequencer with the one-cycle result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state    <= ST_IDLE;
            tcnt     <= '0;
            shreg    <= '0;
            bidx     <= '0;
            par_seen <= 1'b0;
            valid    <= 1'b0;
            data     <= '0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
            brk_flag <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (!line_in) begin
                        state <= ST_START;
                        tcnt  <= '0;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        tcnt <= tcnt + 4'd1;
                        if (tcnt == MID_TICK) begin
                            tcnt  <= '0;
                            bidx  <= '0;
                            state <= line_in ? ST_IDLE : ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        tcnt <= tcnt + 4'd1;
                        if (tcnt == LAST_TICK) begin
                            shreg <= {line_in, shreg[CHAR_W-1:1]};
                            bidx  <= bidx + 3'd1;
                            if ({1'b0, bidx} == len - 4'd1)
                                state <= par_en ? ST_PAR : ST_STOP;
                        end
                    end
                end
                ST_PAR: begin
                    if (tick) begin
                        tcnt <= tcnt + 4'd1;
                        if (tcnt == LAST_TICK) begin
                            par_seen <= line_in;
                            state    <= ST_STOP;
                        end
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        tcnt <= tcnt + 4'd1;
                        if (tcnt == LAST_TICK) begin
                            valid    <= 1'b1;
                            data     <= aligned;
                            brk_flag <= is_brk;
                            frm_err  <= stop_low && !is_brk;
                            par_err  <= par_en && !is_brk &&
                                        (par_seen != parity_bit(aligned, par_odd));
                            state    <= line_in ? ST_IDLE : ST_HOLD;
                        end
                    end
                end
                default: begin
                    if (line_in)
                        state <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_frame_engine.sv
// Module: top of the UART frame engine. Ties the baud generator, transmit
// and receive shifters together, synchronizes the serial input, selects the
// loopback source and drives the inverted modem outputs. Assumes the format
// inputs change only while the three enables are low.
module uart_frame_engine
    import uart_fe_pkg::*;
#(
    parameter int BAUD_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_brg_en,
    input  logic              cfg_tx_en,
    input  logic              cfg_rx_en,
    input  logic [1:0]        cfg_bits_code,
    input  logic              cfg_two_stop,
    input  logic              cfg_tx_par_en,
    input  logic              cfg_tx_par_odd,
    input  logic              cfg_rx_par_en,
    input  logic              cfg_rx_par_odd,
    input  logic              cfg_break,
    input  logic              cfg_loop,
    input  logic              cfg_dtr_bit,
    input  logic              cfg_rts_bit,
    input  logic [BAUD_W-1:0] baud_word,
    input  logic [7:0]        tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [7:0]        rx_data,
    output logic              rx_valid,
    output logic              rx_par_err,
    output logic              rx_frm_err,
    output logic              rx_brk,
    input  logic              serial_in,
    output logic              serial_out,
    output logic              dtr_n,
    output logic              rts_n
);
    localparam int SYNC_LAST = SYNC_STAGES - 1;

    logic                   tick;
    logic                   tx_int_line;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_src;

    uart_fe_baud #(.BAUD_W(BAUD_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (cfg_brg_en),
        .div  (baud_word),
        .tick (tick)
    );

    uart_fe_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .en       (cfg_tx_en),
        .bits_code(cfg_bits_code),
        .two_stop (cfg_two_stop),
        .par_en   (cfg_tx_par_en),
        .par_odd  (cfg_tx_par_odd),
        .brk      (cfg_break),
        .loop     (cfg_loop),
        .data     (tx_data),
        .valid    (tx_valid),
        .ready    (tx_ready),
        .pin_line (serial_out),
        .int_line (tx_int_line)
    );

    // Input synchronizer chain, one flop per stage, idles high.
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                // First stage captures the asynchronous pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b1;
                    else        sync_q[0] <= serial_in;
                end
            end else begin : g_next
                // Later stages pass the level along.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[s] <= 1'b1;
                    else        sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    assign rx_src = cfg_loop ? tx_int_line : sync_q[SYNC_LAST];

    uart_fe_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .en       (cfg_rx_en),
        .bits_code(cfg_bits_code),
        .par_en   (cfg_rx_par_en),
        .par_odd  (cfg_rx_par_odd),
        .line_in  (rx_src),
        .valid    (rx_valid),
        .data     (rx_data),
        .par_err  (rx_par_err),
        .frm_err  (rx_frm_err),
        .brk_flag (rx_brk)
    );

    // Modem outputs show the inverse of their control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dtr_n <= 1'b1;
            rts_n <= 1'b1;
        end else begin
            dtr_n <= !cfg_dtr_bit;
            rts_n <= !cfg_rts_bit;
        end
    end
endmodule

// File: rtl/uart_fe_checker.sv
// Module: property checker for the UART frame engine, bound to the top.
module uart_fe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_break,
    input logic       cfg_loop,
    input logic       cfg_rx_en,
    input logic       cfg_dtr_bit,
    input logic       cfg_rts_bit,
    input logic       serial_out,
    input logic       dtr_n,
    input logic       rts_n,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rx_brk,
    input logic       rx_frm_err
);
    p_break_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_break && !cfg_loop) |=> !serial_out);

    p_loop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_loop |=> serial_out);

    p_rx_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rx_en |=> !rx_valid);

    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_break_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_brk) |-> (rx_data == 8'h00 && !rx_frm_err));

    p_dtr_inv_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (dtr_n == !$past(cfg_dtr_bit)));

    p_rts_inv_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rts_n == !$past(cfg_rts_bit)));
endmodule

bind uart_frame_engine uart_fe_checker u_chk (.*);

// File: tb/tb_uart_frame_engine.sv
`timescale 1ns/1ps
module tb_uart_frame_engine;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_brg_en = 1'b0, cfg_tx_en = 1'b0, cfg_rx_en = 1'b0;
    logic [1:0] cfg_bits_code = 2'd3;
    logic cfg_two_stop = 1'b0, cfg_tx_par_en = 1'b0, cfg_tx_par_odd = 1'b0;
    logic cfg_rx_par_en = 1'b0, cfg_rx_par_odd = 1'b0;
    logic cfg_break = 1'b0, cfg_loop = 1'b0, cfg_dtr_bit = 1'b0, cfg_rts_bit = 1'b0;
    logic [11:0] baud_word = 12'd1;
    logic [7:0] tx_data = 8'h00;
    logic tx_valid = 1'b0;
    logic tx_ready;
    logic [7:0] rx_data;
    logic rx_valid, rx_par_err, rx_frm_err, rx_brk;
    logic serial_in = 1'b1;
    logic serial_out, dtr_n, rts_n;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    uart_frame_engine dut (.*);

    function automatic int bit_clks();
        return 16 * (int'(baud_word) + 1);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Offer one byte and wait until it is accepted.
    task automatic send_byte(input logic [7:0] d);
        @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // Decode one frame seen on serial_out.
    task automatic tx_capture(input int nbits, input bit par_on,
                              output logic [7:0] d, output logic pb, output logic stop_v);
        int guard = 0;
        d = 8'h00;
        pb = 1'b0;
        while (serial_out && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        idle(bit_clks() / 2);
        for (int k = 0; k < nbits; k++) begin
            idle(bit_clks());
            d[k] = serial_out;
        end
        if (par_on) begin
            idle(bit_clks());
            pb = serial_out;
        end
        idle(bit_clks());
        stop_v = serial_out;
    endtask

    task automatic wait_tx_done();
        int guard = 0;
        while (!tx_ready && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        idle(bit_clks());
    endtask

    // Drive one frame onto serial_in.
    task automatic rx_drive(input logic [7:0] d, input int nbits, input bit par_on,
                            input logic pb, input logic stop_v);
        serial_in = 1'b0;
        idle(bit_clks());
        for (int k = 0; k < nbits; k++) begin
            serial_in = d[k];
            idle(bit_clks());
        end
        if (par_on) begin
            serial_in = pb;
            idle(bit_clks());
        end
        serial_in = stop_v;
        idle(bit_clks());
        serial_in = 1'b1;
        idle(2 * bit_clks());
    endtask

    // Wait for one receive strobe and grab its contents.
    task automatic rx_wait(input int window, output bit got, output logic [7:0] d,
                           output logic pe, output logic fe, output logic bk);
        got = 1'b0;
        d = 8'h00; pe = 1'b0; fe = 1'b0; bk = 1'b0;
        for (int i = 0; i < window && !got; i++) begin
            @(negedge clk);
            if (rx_valid) begin
                got = 1'b1;
                d = rx_data; pe = rx_par_err; fe = rx_frm_err; bk = rx_brk;
            end
        end
    endtask

    task automatic set_enabled();
        cfg_brg_en = 1'b1;
        cfg_tx_en  = 1'b1;
        cfg_rx_en  = 1'b1;
    endtask

    task automatic t_reset();
        check(serial_out == 1'b1, "R13 serial_out", serial_out, 1);
        check(dtr_n == 1'b1 && rts_n == 1'b1, "R13 modem", {dtr_n, rts_n}, 3);
        check(rx_valid == 1'b0, "R13 rx_valid", rx_valid, 0);
        check(tx_ready == 1'b0, "R11 ready while tx off", tx_ready, 0);
    endtask

    // R2 and R4: frame contents for a length code and parity setting.
    task automatic t_tx_frame(input logic [1:0] code, input bit par_on, input bit odd,
                              input logic [7:0] d);
        logic [7:0] got_d;
        logic pb, sv;
        logic [7:0] exp_d;
        logic exp_p;
        int nb;
        cfg_bits_code = code; cfg_tx_par_en = par_on; cfg_tx_par_odd = odd;
        nb = 5 + int'(code);
        exp_d = d & (8'hFF >> (3 - nb + 5));
        exp_p = (^exp_d) ^ odd;
        fork
            send_byte(d);
            tx_capture(nb, par_on, got_d, pb, sv);
        join
        check(got_d == exp_d, "R2 tx data bits", got_d, exp_d);
        check(sv == 1'b1, "R2 tx stop level", sv, 1);
        if (par_on) check(pb == exp_p, "R4 tx parity", pb, exp_p);
        wait_tx_done();
    endtask

    // R1: bit period from an internal edge pair.
    task automatic t_bit_period(input logic [11:0] bw);
        int cnt = 0;
        baud_word = bw;
        cfg_bits_code = 2'd3; cfg_tx_par_en = 1'b0;
        fork
            send_byte(8'h55);
            begin
                while (serial_out) @(negedge clk);
                while (!serial_out) @(negedge clk);
                while (serial_out) begin @(negedge clk); cnt++; end
            end
        join
        check(cnt == bit_clks(), "R1 bit period", cnt, bit_clks());
        wait_tx_done();
    endtask

    // R3: frame length with one or two stop bits.
    task automatic t_stop_len(input bit two);
        int cnt = 0;
        int exp;
        cfg_two_stop = two; cfg_bits_code = 2'd3; cfg_tx_par_en = 1'b0;
        exp = (two ? 11 : 10) * bit_clks();
        fork
            send_byte(8'hFF);
            begin
                while (serial_out) @(negedge clk);
                while (!tx_ready) begin @(negedge clk); cnt++; end
            end
        join
        check(cnt <= exp + 4 && cnt + 8 >= exp, "R3 frame length", cnt, exp);
        cfg_two_stop = 1'b0;
        idle(bit_clks());
    endtask

    // R5..R8: receive one frame and compare the result.
    task automatic t_rx(input string tag, input logic [1:0] code, input bit par_on,
                        input bit odd, input logic [7:0] d, input logic pb,
                        input logic stop_v, input logic [7:0] exp_d,
                        input logic exp_pe, input logic exp_fe, input logic exp_bk);
        bit got;
        logic [7:0] rd;
        logic pe, fe, bk;
        cfg_bits_code = code; cfg_rx_par_en = par_on; cfg_rx_par_odd = odd;
        fork
            rx_drive(d, 5 + int'(code), par_on, pb, stop_v);
            rx_wait(16 * bit_clks(), got, rd, pe, fe, bk);
        join
        check(got, {tag, " strobe"}, got, 1);
        check(rd == exp_d, {tag, " data"}, rd, exp_d);
        check({pe, fe, bk} == {exp_pe, exp_fe, exp_bk}, {tag, " flags"},
              {pe, fe, bk}, {exp_pe, exp_fe, exp_bk});
        cfg_rx_par_en = 1'b0;
    endtask

    // R10: loopback carries data, pin parked high, serial_in ignored.
    task automatic t_loop_data();
        bit got;
        logic [7:0] rd;
        logic pe, fe, bk;
        int low_seen = 0;
        cfg_bits_code = 2'd3; cfg_tx_par_en = 1'b1; cfg_rx_par_en = 1'b1;
        cfg_tx_par_odd = 1'b1; cfg_rx_par_odd = 1'b1;
        serial_in = 1'b0;
        cfg_loop = 1'b1;
        idle(4);
        fork
            send_byte(8'hA5);
            rx_wait(16 * bit_clks(), got, rd, pe, fe, bk);
            for (int i = 0; i < 12 * bit_clks(); i++) begin
                @(negedge clk);
                if (!serial_out) low_seen++;
            end
        join
        check(got && rd == 8'hA5 && !pe && !fe && !bk, "R10 loop data", rd, 8'hA5);
        check(low_seen == 0, "R10 pin high in loop", low_seen, 0);
        serial_in = 1'b1;
        idle(4);
        cfg_loop = 1'b0;
        cfg_tx_par_en = 1'b0; cfg_rx_par_en = 1'b0;
        cfg_tx_par_odd = 1'b0; cfg_rx_par_odd = 1'b0;
        idle(2 * bit_clks());
    endtask

    // R10 and R8: a looped-back break arrives as a break character.
    task automatic t_loop_break();
        bit got;
        logic [7:0] rd;
        logic pe, fe, bk;
        cfg_bits_code = 2'd3;
        cfg_loop = 1'b1;
        idle(2);
        fork
            begin
                cfg_break = 1'b1;
                idle(12 * bit_clks());
                cfg_break = 1'b0;
            end
            rx_wait(14 * bit_clks(), got, rd, pe, fe, bk);
        join
        check(got && bk && !fe && rd == 8'h00, "R8 looped break", {got, bk, fe}, 3'b110);
        idle(2 * bit_clks());
        cfg_loop = 1'b0;
        idle(4);
    endtask

    // R9: break on the pin.
    task automatic t_break_pin();
        cfg_break = 1'b1;
        idle(2);
        check(serial_out == 1'b0, "R9 break low", serial_out, 0);
        idle(100);
        check(serial_out == 1'b0, "R9 break held", serial_out, 0);
        cfg_break = 1'b0;
        idle(2);
        check(serial_out == 1'b1, "R9 break released", serial_out, 1);
    endtask

    // R11: disabled transmitter and receiver.
    task automatic t_disables();
        bit got;
        logic [7:0] rd;
        logic pe, fe, bk;
        int rdy = 0;
        int low = 0;
        cfg_tx_en = 1'b0;
        tx_data = 8'h00;
        tx_valid = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (tx_ready) rdy++;
            if (!serial_out) low++;
        end
        tx_valid = 1'b0;
        check(rdy == 0 && low == 0, "R11 tx disabled", rdy + low, 0);
        cfg_tx_en = 1'b1;
        cfg_rx_en = 1'b0;
        cfg_bits_code = 2'd3;
        fork
            rx_drive(8'h3C, 8, 1'b0, 1'b0, 1'b1);
            rx_wait(13 * bit_clks(), got, rd, pe, fe, bk);
        join
        check(!got, "R11 rx disabled", got, 0);
        cfg_rx_en = 1'b1;
        idle(4);
    endtask

    // R1: with the baud generator off, a started frame does not advance.
    task automatic t_brg_off();
        int high = 0;
        cfg_brg_en = 1'b0;
        send_byte(8'hFF);
        idle(2);
        for (int i = 0; i < 10 * bit_clks(); i++) begin
            @(negedge clk);
            if (serial_out) high++;
        end
        check(high == 0, "R1 stall without ticks", high, 0);
        cfg_tx_en = 1'b0;
        idle(2);
        check(serial_out == 1'b1, "R11 abort idles line", serial_out, 1);
        cfg_brg_en = 1'b1;
        cfg_tx_en = 1'b1;
        idle(4);
    endtask

    // R12: modem outputs follow the inverse of their bits.
    task automatic t_modem();
        cfg_dtr_bit = 1'b1; cfg_rts_bit = 1'b0;
        @(negedge clk);
        check(dtr_n == 1'b0 && rts_n == 1'b1, "R12 modem a", {dtr_n, rts_n}, 2'b01);
        cfg_dtr_bit = 1'b0; cfg_rts_bit = 1'b1;
        @(negedge clk);
        check(dtr_n == 1'b1 && rts_n == 1'b0, "R12 modem b", {dtr_n, rts_n}, 2'b10);
    endtask

    initial begin
        idle(4);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        set_enabled();
        idle(4);
        t_modem();
        t_bit_period(12'd1);
        t_bit_period(12'd3);
        baud_word = 12'd1;
        t_tx_frame(2'd3, 1'b0, 1'b0, 8'hC3);
        t_tx_frame(2'd0, 1'b0, 1'b0, 8'hF5);
        t_tx_frame(2'd1, 1'b1, 1'b0, 8'h2B);
        t_tx_frame(2'd2, 1'b1, 1'b1, 8'h7E);
        t_stop_len(1'b0);
        t_stop_len(1'b1);
        t_rx("R5 8-bit", 2'd3, 1'b0, 1'b0, 8'hC3, 1'b0, 1'b1, 8'hC3, 1'b0, 1'b0, 1'b0);
        t_rx("R5 5-bit", 2'd0, 1'b0, 1'b0, 8'h15, 1'b0, 1'b1, 8'h15, 1'b0, 1'b0, 1'b0);
        t_rx("R6 odd ok", 2'd3, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0);
        t_rx("R6 odd bad", 2'd3, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b0);
        t_rx("R6 even bad", 2'd2, 1'b1, 1'b0, 8'h07, 1'b0, 1'b1, 8'h07, 1'b1, 1'b0, 1'b0);
        t_rx("R7 framing", 2'd3, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b1, 1'b0);
        t_rx("R8 break", 2'd3, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        t_break_pin();
        t_loop_data();
        t_loop_break();
        t_disables();
        t_brg_off();
        finish_run();
    end
endmodule